// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 32-bit virtual address into a physical address in the same cycle that the address is presented. The top two address bits pick a segment. Two kernel windows skip translation altogether. Each is a fixed 512 MB view of the bottom of physical space, and the only difference between them is that one is cacheable and the other is not. The rest of the address space is looked up in a fully associative table of page entries, with 4 KB pages.

A lookup is an address, a user/kernel flag, a store flag and the current 6-bit address-space tag. The block returns the physical address, whether the address went through the table, and whether the access may be cached. It also raises one of three exclusive exceptions: address error, table miss or modification fault. No hardware walk exists. Miss-handling software maintains the table through a separate port, which offers indexed write, random write, read-back and probe.

The random-write slot comes from a free-running down-counter. The counter never selects the lowest entries, so those entries can hold translations that must stay in place.

Top module: `seg_xlate`

## Requirements
- R1: Addresses with bit 31 clear are translated through the table. On a hit, `pa` is the entry frame number (bits 31:12) joined to `va[11:0]`, and `mapped` is 1.
- R2: Addresses 0x80000000 to 0x9FFFFFFF in kernel mode give `pa = {3'b000, va[28:0]}`, `mapped=0` and `cacheable=1`, with no exception, whatever the table holds.
- R3: Addresses 0xA0000000 to 0xBFFFFFFF in kernel mode give `pa = {3'b000, va[28:0]}`, `mapped=0` and `cacheable=0`, with no exception.
- R4: Addresses 0xC0000000 and above are translated through the table. `cacheable` is the inverse of the entry's no-cache flag, both here and for R1 hits.
- R5: An entry matches when its page number equals `va[31:12]` and either its global flag is set or its tag equals `cur_asid`. A lookup with no matching entry raises `miss`.
- R6: A matching entry whose valid flag is clear raises `miss`.
- R7: A user-mode access with `va[31]=1` raises `addr_err`, and neither `miss` nor `mod_fault` is raised.
- R8: A store that hits a valid entry whose dirty flag is clear raises `mod_fault`. A load to the same entry raises nothing. At most one of `addr_err`, `miss` and `mod_fault` is high at a time.
- R9: `rand_index` is 63 after reset and falls by one at each clock edge. The edge after it reads 8 brings it back to 63. `op_wr_rnd` writes the entry that `rand_index` names at that edge.
- R10: `op_wr_idx` writes the entry at `op_index`. If `op_read` is high at an edge, the fields of entry `op_index` appear on the `rd_*` outputs after that edge. The flag field is `{global, valid, dirty, nocache}`, bit 3 down to bit 0.
- R11: If `op_probe` is high at an edge, then after that edge `probe_index` is the lowest entry that matches `ent_vpn`/`ent_asid` under the R5 rule, and `probe_fail` is 0. When nothing matches, `probe_fail` is 1. After reset, every entry is invalid and `probe_fail` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| va | input | 32 | Lookup virtual address |
| user_mode | input | 1 | 1 for a user-mode access |
| is_store | input | 1 | 1 for a store |
| cur_asid | input | 6 | Current address-space tag |
| pa | output | 32 | Physical address |
| mapped | output | 1 | Address went through the table |
| cacheable | output | 1 | Access may be cached |
| addr_err | output | 1 | Address error |
| miss | output | 1 | Table miss or invalid entry |
| mod_fault | output | 1 | Store to a clean page |
| op_wr_idx | input | 1 | Indexed write strobe |
| op_wr_rnd | input | 1 | Random write strobe |
| op_read | input | 1 | Read strobe |
| op_probe | input | 1 | Probe strobe |
| op_index | input | 6 | Entry index for indexed write and read |
| ent_vpn | input | 20 | Page number to write or probe |
| ent_asid | input | 6 | Tag to write or probe |
| ent_pfn | input | 20 | Frame number to write |
| ent_flags | input | 4 | {global, valid, dirty, nocache} to write |
| rd_vpn | output | 20 | Read-back page number |
| rd_asid | output | 6 | Read-back tag |
| rd_pfn | output | 20 | Read-back frame number |
| rd_flags | output | 4 | Read-back flags |
| probe_index | output | 6 | Probe result index |
| probe_fail | output | 1 | Probe found no match |
| rand_index | output | 6 | Current random-write slot |

## Verification
The assertions check several properties on every cycle: the three exceptions stay exclusive, a user access to the upper half raises only the address error, the direct windows pass the low 29 bits through with the right cacheability, and the random slot stays in range and steps as R9 requires. The lookup results themselves need the bench's scenarios. These include frame substitution, tag and global matching, invalid entries, clean-page stores, the read-back, probe results and random-write placement. Each depends on which table contents were loaded earlier.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int ENTRIES    = 64,
  parameter int ASID_W     = 6,
  parameter int RAND_FLOOR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       va,
  input  logic              user_mode,
  input  logic              is_store,
  input  logic [ASID_W-1:0] cur_asid,
  output logic [31:0]       pa,
  output logic              mapped,
  output logic              cacheable,
  output logic              addr_err,
  output logic              miss,
  output logic              mod_fault,
  input  logic              op_wr_idx,
  input  logic              op_wr_rnd,
  input  logic              op_read,
  input  logic              op_probe,
  input  logic [$clog2(ENTRIES)-1:0] op_index,
  input  logic [19:0]       ent_vpn,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic [19:0]       ent_pfn,
  input  logic [3:0]        ent_flags,
  output logic [19:0]       rd_vpn,
  output logic [ASID_W-1:0] rd_asid,
  output logic [19:0]       rd_pfn,
  output logic [3:0]        rd_flags,
  output logic [$clog2(ENTRIES)-1:0] probe_index,
  output logic              probe_fail,
  output logic [$clog2(ENTRIES)-1:0] rand_index
);
  localparam int IW = $clog2(ENTRIES);
  localparam logic [IW-1:0] TOP = IW'(ENTRIES - 1);
  localparam logic [IW-1:0] FLOOR = IW'(RAND_FLOOR);

  logic [19:0]       t_vpn   [ENTRIES];
  logic [19:0]       t_pfn   [ENTRIES];
  logic [ASID_W-1:0] t_asid  [ENTRIES];
  logic [3:0]        t_flags [ENTRIES];

  logic [ENTRIES-1:0] lk_match, pr_match;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = (t_vpn[g] == va[31:12]) &&
                         (t_flags[g][3] || t_asid[g] == cur_asid);
    assign pr_match[g] = (t_vpn[g] == ent_vpn) &&
                         (t_flags[g][3] || t_asid[g] == ent_asid);
  end

  logic [IW-1:0] lk_idx, pr_idx;
  always_comb begin
    lk_idx = '0;
    pr_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) lk_idx = IW'(i);
      if (pr_match[i]) pr_idx = IW'(i);
    end
  end

  wire        lk_hit   = |lk_match;
  wire [3:0]  hit_flg  = t_flags[lk_idx];
  wire        direct   = (va[31:30] == 2'b10);

  assign mapped    = !direct;
  assign addr_err  = user_mode && va[31];
  assign pa        = direct ? {3'b000, va[28:0]} : {t_pfn[lk_idx], va[11:0]};
  assign cacheable = direct ? !va[29] : !hit_flg[0];
  assign miss      = !addr_err && mapped && !(lk_hit && hit_flg[2]);
  assign mod_fault = !addr_err && mapped && lk_hit && hit_flg[2] &&
                     is_store && !hit_flg[1];

  wire           do_wr  = op_wr_idx || op_wr_rnd;
  wire [IW-1:0]  wr_sel = op_wr_idx ? op_index : rand_index;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        t_vpn[i]   <= '0;
        t_pfn[i]   <= '0;
        t_asid[i]  <= '0;
        t_flags[i] <= '0;
      end
      rand_index  <= TOP;
      rd_vpn      <= '0;
      rd_pfn      <= '0;
      rd_asid     <= '0;
      rd_flags    <= '0;
      probe_index <= '0;
      probe_fail  <= 1'b0;
    end else begin
      rand_index <= (rand_index == FLOOR) ? TOP : rand_index - 1'b1;
      if (do_wr) begin
        t_vpn[wr_sel]   <= ent_vpn;
        t_pfn[wr_sel]   <= ent_pfn;
        t_asid[wr_sel]  <= ent_asid;
        t_flags[wr_sel] <= ent_flags;
      end
      if (op_read) begin
        rd_vpn   <= t_vpn[op_index];
        rd_pfn   <= t_pfn[op_index];
        rd_asid  <= t_asid[op_index];
        rd_flags <= t_flags[op_index];
      end
      if (op_probe) begin
        probe_index <= pr_idx;
        probe_fail  <= !(|pr_match);
      end
    end
  end

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_err, miss, mod_fault}));
  assert_user_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && va[31]) |-> (addr_err && !miss && !mod_fault));
  assert_kseg_cached_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_mode && va[31:29] == 3'b100) |-> (cacheable && pa[28:0] == va[28:0] && pa[31:29] == 3'b000));
  assert_kseg_uncached_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_mode && va[31:29] == 3'b101) |-> (!cacheable && !miss && pa[28:0] == va[28:0]));
  assert_rand_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rand_index >= FLOOR);
  assert_rand_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rand_index) != FLOOR && $past(rst_n)) |-> rand_index == $past(rand_index) - 1'b1);
endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [31:0] va = 0; logic user_mode = 0, is_store = 0; logic [5:0] cur_asid = 0;
  logic [31:0] pa; logic mapped, cacheable, addr_err, miss, mod_fault;
  logic op_wr_idx = 0, op_wr_rnd = 0, op_read = 0, op_probe = 0;
  logic [5:0] op_index = 0; logic [19:0] ent_vpn = 0; logic [5:0] ent_asid = 0;
  logic [19:0] ent_pfn = 0; logic [3:0] ent_flags = 0;
  logic [19:0] rd_vpn, rd_pfn; logic [5:0] rd_asid; logic [3:0] rd_flags;
  logic [5:0] probe_index, rand_index; logic probe_fail;

  int checks = 0, errors = 0;

  seg_xlate dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] vpn_of(int i);
    return (i < 32) ? 20'h00100 + 20'(i) : 20'hC0000 + 20'(i);
  endfunction
  function automatic logic [19:0] pfn_of(int i);
    return 20'h30000 + 20'(i * 7);
  endfunction
  function automatic logic [3:0] flg_of(int i);
    return {i % 8 == 0, i != 5, i % 2 == 1, i % 3 == 0};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R9 reset rand", 32'(rand_index), 63);
    chk("R11 reset probe_fail", 32'(probe_fail), 0);
    chk("R10 reset rd_flags", 32'(rd_flags), 0);
    va = 32'h00100ABC;
    #1 chk("R6 reset miss", 32'(miss), 1);

    r = 63;
    for (int c = 0; c < 130; c++) begin
      @(negedge clk);
      r = (r == 8) ? 6'd63 : r - 6'd1;
      chk("R9 rand step", 32'(rand_index), 32'(r));
    end

    for (int i = 0; i < 64; i++) begin
      op_wr_idx = 1; op_index = 6'(i); ent_vpn = vpn_of(i); ent_pfn = pfn_of(i);
      ent_asid = 6'(i); ent_flags = flg_of(i);
      @(negedge clk);
    end
    op_wr_idx = 0;

    for (int i = 0; i < 64; i++) begin
      op_read = 1; op_index = 6'(i);
      @(negedge clk);
      chk("R10 read vpn", 32'(rd_vpn), 32'(vpn_of(i)));
      chk("R10 read pfn", 32'(rd_pfn), 32'(pfn_of(i)));
      chk("R10 read flags", 32'(rd_flags), 32'(flg_of(i)));
      chk("R10 read asid", 32'(rd_asid), i);
    end
    op_read = 0;

    for (int i = 0; i < 64; i++) begin
      logic [3:0] f;
      f = flg_of(i);
      va = {vpn_of(i), 12'h5A7}; cur_asid = 6'(i); user_mode = (i < 32); is_store = 0;
      #1;
      if (i == 5) chk("R6 invalid miss", 32'(miss), 1);
      else begin
        chk(i < 32 ? "R1 user pa" : "R4 kernel pa", pa, {pfn_of(i), 12'h5A7});
        chk("R4 cacheable", 32'(cacheable), 32'(!f[0]));
        chk("R1 mapped", 32'(mapped), 1);
        chk("R5 hit", 32'(miss), 0);
      end
      is_store = 1;
      #1 chk("R8 store fault", 32'(mod_fault), 32'(i != 5 && !f[1]));
      is_store = 0; cur_asid = 6'(i + 1);
      #1 chk("R5 asid mismatch", 32'(miss), 32'(!(f[3] && i != 5)));
      if (i >= 32) begin
        user_mode = 1; cur_asid = 6'(i);
        #1 chk("R7 user high", 32'({addr_err, miss, mod_fault}), 32'b100);
      end
      @(negedge clk);
    end
    user_mode = 0; is_store = 0;

    for (int k = 0; k < 64; k++) begin
      logic [28:0] off;
      off = 29'(k * 29'h0123457 + 3);
      va = {3'b100, off}; #1;
      chk("R2 kseg cached pa", pa, {3'b000, off});
      chk("R2 kseg cached flags", 32'({cacheable, mapped, miss, mod_fault}), 32'b1000);
      va = {3'b101, off}; is_store = 1; #1;
      chk("R3 kseg uncached pa", pa, {3'b000, off});
      chk("R3 kseg uncached flags", 32'({cacheable, mapped, miss, mod_fault}), 32'b0000);
      is_store = 0;
    end

    for (int i = 0; i < 64; i++) begin
      op_probe = 1; ent_vpn = vpn_of(i); ent_asid = 6'(i);
      @(negedge clk);
      chk("R11 probe idx", 32'(probe_index), i);
      chk("R11 probe ok", 32'(probe_fail), 0);
    end
    ent_vpn = 20'h77777; @(negedge clk);
    chk("R11 probe fail", 32'(probe_fail), 1);
    op_probe = 0;

    r = rand_index;
    op_wr_rnd = 1; ent_vpn = 20'h55555; ent_pfn = 20'hABCDE; ent_asid = 6'd9; ent_flags = 4'b0110;
    @(negedge clk);
    op_wr_rnd = 0; op_read = 1; op_index = r;
    @(negedge clk);
    op_read = 0;
    chk("R9 rnd write vpn", 32'(rd_vpn), 32'h55555);
    chk("R9 rnd write pfn", 32'(rd_pfn), 32'hABCDE);
    va = 32'h55555123; cur_asid = 6'd9; #1;
    chk("R9 rnd lookup", pa, 32'hABCDE123);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule